// File: doc/BRIEF.md
# Strict Signature Verification Sequencer

This block orders the rejection checks of a strict Edwards-curve signature verification and reduces their outcome to one result code. A command carries the encoded R half of the signature, a framing-error flag from the message stream and a flag that selects the cached public key. The sequencer does not compute anything itself. It starts five child engines one after another, waits for each completion handshake, and reads that engine's status flags.

The engines run in a fixed order: the canonicality test on S, the decode of A, the decode of R, the challenge hash with its reduction, and the double scalar multiplication that returns an encoding. All rejection checks come before any equation work. The first failure ends the run, and no later engine is started. If every check passes, the sequencer compares the returned encoding with the R latched at command time. The result code is held, and a one-cycle done pulse marks it, until the next command is taken.

Top module: `sig_verify_seq`

## Requirements
- R1: After reset, cmd_ready_o is 1, eng_start_o is 0, done_o is 0 and res_o is 0.
- R2: A command accepted with cmd_frame_err_i=1 gives res_o=1 (framing), with done_o high one cycle after acceptance and no engine started. Framing takes precedence over a missing key.
- R3: A command with cmd_cached_i=1 accepted while key_valid_i=0 gives res_o=2 (no key), with done_o high one cycle after acceptance and no engine started.
- R4: Engines are started in order through eng_start_o bits 0 (S check), 1 (decode A), 2 (decode R), 3 (challenge), 4 (multiply and encode). Each start is a one-cycle pulse with at most one bit set. Bit 0 rises one cycle after acceptance, and each later bit rises one cycle after the done of the previous engine.
- R5: If the S engine finishes with eng_bad_i[0]=1, res_o=4 (non-canonical S) and no later engine starts.
- R6: If decode A or decode R finishes with its eng_bad_i bit set, res_o=3 (malformed), even when its eng_small_i bit is also set, and no later engine starts.
- R7: If decode A or decode R finishes with only its eng_small_i bit set, res_o=5 (small order) and no later engine starts.
- R8: When the multiply engine finishes, res_o=0 (success) if enc_i equals the sig_r_i latched at acceptance, and 6 (equation failure) otherwise.
- R9: done_o is a one-cycle pulse. res_o then holds until a new command is accepted. cmd_ready_o is 0 while engines are pending, and commands offered then are ignored.
- R10: A done from any engine other than the one currently started, whatever its flags, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Command can be accepted |
| cmd_cached_i | input | 1 | Command uses the cached public key |
| cmd_frame_err_i | input | 1 | Message stream framing fault |
| key_valid_i | input | 1 | Cached key is loaded |
| sig_r_i | input | ENC_W | Encoded R from the signature |
| eng_start_o | output | 5 | Start pulse per child engine |
| eng_done_i | input | 5 | Completion pulse per child engine |
| eng_bad_i | input | 5 | Malformed / non-canonical flag per engine |
| eng_small_i | input | 5 | Small-order flag per engine |
| enc_i | input | ENC_W | Encoding returned by the multiply engine |
| done_o | output | 1 | Result valid pulse |
| res_o | output | 3 | Result code |

## Verification
The bench aims at the early exits. A sequencer that checked the key before framing, or that started the S engine on an early error, would show the wrong code or a start pulse where none is expected. It raises malformed and small-order together to expose a priority mix-up, and it pulses stray dones from other engines with every flag set, which a design that did not index by the current step would take as failures. It also offers commands while engines are pending and compares against an R value that changes afterwards, which catches a design that does not latch R or that accepts commands mid-run.

// File: rtl/sig_verify_pkg.sv
package sig_verify_pkg;
  localparam int unsigned NENG  = 5;
  localparam int unsigned STP_W = 3;

  typedef enum logic [2:0] {
    RES_OK        = 3'd0,
    RES_FRAME     = 3'd1,
    RES_NOKEY     = 3'd2,
    RES_MALFORMED = 3'd3,
    RES_NONCANON  = 3'd4,
    RES_SMALL     = 3'd5,
    RES_EQFAIL    = 3'd6
  } res_e;

  localparam logic [STP_W-1:0] STP_S    = 3'd0;
  localparam logic [STP_W-1:0] STP_A    = 3'd1;
  localparam logic [STP_W-1:0] STP_R    = 3'd2;
  localparam logic [STP_W-1:0] STP_HASH = 3'd3;
  localparam logic [STP_W-1:0] STP_MUL  = 3'd4;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} st_e;
endpackage

// File: rtl/sv_classify.sv
module sv_classify
  import sig_verify_pkg::*;
(
  input  logic [STP_W-1:0] step_i,
  input  logic             bad_i,
  input  logic             small_i,
  input  logic             match_i,
  output logic             fail_o,
  output logic             last_o,
  output res_e             code_o
);
  always_comb begin
    fail_o = 1'b0;
    last_o = 1'b0;
    code_o = RES_OK;
    case (step_i)
      STP_S: begin
        fail_o = bad_i;
        code_o = RES_NONCANON;
      end
      STP_A, STP_R: begin
        fail_o = bad_i | small_i;
        code_o = bad_i ? RES_MALFORMED : RES_SMALL;
      end
      STP_MUL: begin
        last_o = 1'b1;
        fail_o = ~match_i;
        code_o = match_i ? RES_OK : RES_EQFAIL;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sv_start_gen.sv
module sv_start_gen
  import sig_verify_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic [STP_W-1:0] idx_i,
  output logic [NENG-1:0]  start_o
);
  for (genvar g = 0; g < NENG; g++) begin : g_eng
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) start_o[g] <= 1'b0;
      else         start_o[g] <= fire_i && (idx_i == STP_W'(g));
    end
  end
endmodule

// File: rtl/sv_enc_cmp.sv
module sv_enc_cmp #(
  parameter int unsigned ENC_W = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [ENC_W-1:0] ref_i,
  input  logic [ENC_W-1:0] enc_i,
  output logic             match_o
);
  logic [ENC_W-1:0] ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ref_q <= '0;
    else if (load_i) ref_q <= ref_i;
  end

  assign match_o = (enc_i == ref_q);
endmodule

// File: rtl/sig_verify_seq.sv
module sig_verify_seq
  import sig_verify_pkg::*;
#(
  parameter int unsigned ENC_W = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  output logic             cmd_ready_o,
  input  logic             cmd_cached_i,
  input  logic             cmd_frame_err_i,
  input  logic             key_valid_i,
  input  logic [ENC_W-1:0] sig_r_i,
  output logic [4:0]       eng_start_o,
  input  logic [4:0]       eng_done_i,
  input  logic [4:0]       eng_bad_i,
  input  logic [4:0]       eng_small_i,
  input  logic [ENC_W-1:0] enc_i,
  output logic             done_o,
  output logic [2:0]       res_o
);
  st_e              st_q;
  logic [STP_W-1:0] step_q;
  res_e             res_q;
  logic             done_q;

  logic             accept, early, cur_done, fail, last, match, fire;
  logic [STP_W-1:0] next_idx;
  res_e             early_code, step_code;

  assign cmd_ready_o = (st_q != ST_RUN);
  assign accept      = cmd_valid_i && cmd_ready_o;

  // framing outranks the key check
  assign early      = cmd_frame_err_i || (cmd_cached_i && !key_valid_i);
  assign early_code = cmd_frame_err_i ? RES_FRAME : RES_NOKEY;

  // only the engine currently started may advance the sequence
  assign cur_done = (st_q == ST_RUN) && eng_done_i[step_q];

  sv_enc_cmp #(.ENC_W(ENC_W)) u_cmp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .ref_i   (sig_r_i),
    .enc_i   (enc_i),
    .match_o (match)
  );

  sv_classify u_cls (
    .step_i  (step_q),
    .bad_i   (eng_bad_i[step_q]),
    .small_i (eng_small_i[step_q]),
    .match_i (match),
    .fail_o  (fail),
    .last_o  (last),
    .code_o  (step_code)
  );

  assign fire     = (accept && !early) || (cur_done && !fail && !last);
  assign next_idx = accept ? STP_S : step_q + STP_W'(1);

  sv_start_gen u_start (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (fire),
    .idx_i   (next_idx),
    .start_o (eng_start_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      step_q <= STP_S;
      res_q  <= RES_OK;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        step_q <= STP_S;
        if (early) begin
          st_q   <= ST_DONE;
          res_q  <= early_code;
          done_q <= 1'b1;
        end else begin
          st_q <= ST_RUN;
        end
      end else if (cur_done) begin
        if (fail || last) begin
          st_q   <= ST_DONE;
          res_q  <= step_code;
          done_q <= 1'b1;
        end else begin
          step_q <= next_idx;
        end
      end
    end
  end

  assign done_o = done_q;
  assign res_o  = res_q;
endmodule

// File: rtl/sig_verify_seq_chk.sv
module sig_verify_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_valid_i,
  input logic       cmd_ready_o,
  input logic       cmd_cached_i,
  input logic       cmd_frame_err_i,
  input logic       key_valid_i,
  input logic [4:0] eng_start_o,
  input logic       done_o,
  input logic [2:0] res_o
);
  AST_START_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(eng_start_o)); // R4

  AST_NO_START_WHEN_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> (eng_start_o == 5'd0)); // R4

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9

  AST_DONE_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cmd_ready_o); // R9

  AST_RES_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(res_o)); // R9

  AST_FRAME_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o && cmd_frame_err_i)
      |=> (done_o && res_o == 3'd1 && eng_start_o == 5'd0)); // R2

  AST_NOKEY_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o && !cmd_frame_err_i && cmd_cached_i && !key_valid_i)
      |=> (done_o && res_o == 3'd2 && eng_start_o == 5'd0)); // R3
endmodule

bind sig_verify_seq sig_verify_seq_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .cmd_valid_i     (cmd_valid_i),
  .cmd_ready_o     (cmd_ready_o),
  .cmd_cached_i    (cmd_cached_i),
  .cmd_frame_err_i (cmd_frame_err_i),
  .key_valid_i     (key_valid_i),
  .eng_start_o     (eng_start_o),
  .done_o          (done_o),
  .res_o           (res_o)
);

// File: tb/sig_verify_seq_tb.sv
module sig_verify_seq_tb_top;
  localparam int ENC_W = 256;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cmd_valid_i = 1'b0;
  logic             cmd_ready_o;
  logic             cmd_cached_i = 1'b0;
  logic             cmd_frame_err_i = 1'b0;
  logic             key_valid_i = 1'b0;
  logic [ENC_W-1:0] sig_r_i = '0;
  logic [4:0]       eng_start_o;
  logic [4:0]       eng_done_i = '0;
  logic [4:0]       eng_bad_i = '0;
  logic [4:0]       eng_small_i = '0;
  logic [ENC_W-1:0] enc_i = '0;
  logic             done_o;
  logic [2:0]       res_o;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  sig_verify_seq #(.ENC_W(ENC_W)) dut_i (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [ENC_W-1:0] rnd_enc();
    logic [ENC_W-1:0] v;
    for (int i = 0; i < ENC_W / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  // fail_at: 0 S, 1 A, 2 R, other = none; kind: 0 malformed, 1 small, 2 both
  function automatic int exp_code(bit fr, bit ca, bit kv, int fail_at, int kind, bit mt);
    if (fr) return 1;
    if (ca && !kv) return 2;
    if (fail_at == 0) return 4;
    if (fail_at == 1 || fail_at == 2) return (kind == 1) ? 5 : 3;
    return mt ? 0 : 6;
  endfunction

  function automatic int exp_mask(bit fr, bit ca, bit kv, int fail_at);
    if (fr || (ca && !kv)) return 0;
    if (fail_at >= 0 && fail_at <= 2) return (1 << (fail_at + 1)) - 1;
    return 5'b11111;
  endfunction

  function automatic string code_tag(int c);
    case (c)
      1: return "R2";
      2: return "R3";
      3: return "R6";
      4: return "R5";
      5: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic run_case(input bit fr, input bit ca, input bit kv, input int fail_at,
                          input int kind, input bit mt, input bit spur, input bit poke);
    logic [ENC_W-1:0] r_val;
    int ecode, emask, nxt, guard;
    logic [4:0] seen;
    ecode = exp_code(fr, ca, kv, fail_at, kind, mt);
    emask = exp_mask(fr, ca, kv, fail_at);
    r_val = rnd_enc();
    seen = '0;
    nxt = 0;
    guard = 0;
    @(negedge clk_i);
    chk(cmd_ready_o == 1'b1, "R9", cmd_ready_o, 1);
    cmd_valid_i = 1; cmd_frame_err_i = fr; cmd_cached_i = ca; key_valid_i = kv; sig_r_i = r_val;
    @(negedge clk_i);
    cmd_valid_i = 0; cmd_frame_err_i = 0; cmd_cached_i = 0;
    sig_r_i = ~r_val; // latched copy must be used
    while (!done_o && guard < 300) begin
      guard++;
      if (eng_start_o != 0) begin
        int e, dly;
        e = nxt;
        chk(eng_start_o == 5'(1 << e), "R4", eng_start_o, 1 << e);
        seen |= eng_start_o;
        nxt++;
        dly = $urandom % 4;
        if (poke && dly == 0) dly = 1;
        repeat (dly) begin
          if (spur) begin
            int j;
            j = (e + 1 + $urandom % 4) % 5;
            eng_done_i[j] = 1; eng_bad_i = '1; eng_small_i = '1; enc_i = rnd_enc();
          end
          if (poke) begin
            cmd_valid_i = 1; cmd_frame_err_i = 1;
          end
          @(negedge clk_i);
          eng_done_i = '0; eng_bad_i = '0; eng_small_i = '0;
          cmd_valid_i = 0; cmd_frame_err_i = 0;
          chk(done_o == 1'b0 && eng_start_o == 0, spur ? "R10" : "R9", done_o, 0);
        end
        eng_done_i[e] = 1;
        if (e == fail_at && e == 0) eng_bad_i[0] = 1;
        if (e == fail_at && (e == 1 || e == 2)) begin
          eng_bad_i[e]   = (kind != 1);
          eng_small_i[e] = (kind != 0);
        end
        if (e == 4) enc_i = mt ? r_val : (r_val ^ (ENC_W'(1) << ($urandom % ENC_W)));
        @(negedge clk_i);
        eng_done_i = '0; eng_bad_i = '0; eng_small_i = '0;
      end else begin
        @(negedge clk_i);
      end
    end
    chk(done_o == 1'b1, "R9", done_o, 1);
    chk(int'(res_o) == ecode, code_tag(ecode), res_o, ecode);
    chk(int'(seen) == emask, (emask == 0) ? code_tag(ecode) : "R4", seen, emask);
    repeat (3) begin
      @(negedge clk_i);
      chk(done_o == 1'b0 && int'(res_o) == ecode, "R9", res_o, ecode);
    end
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'h1d5e_0077);
    repeat (3) @(negedge clk_i);
    chk(cmd_ready_o == 1 && eng_start_o == 0 && done_o == 0 && res_o == 0, "R1", res_o, 0);
    rst_ni = 1;
    @(negedge clk_i);
    chk(cmd_ready_o == 1 && eng_start_o == 0 && done_o == 0 && res_o == 0, "R1", eng_start_o, 0);

    run_case(1, 0, 1, 5, 0, 1, 0, 0); // R2
    run_case(1, 1, 0, 5, 0, 1, 0, 0); // R2 precedence over R3
    run_case(0, 1, 0, 5, 0, 1, 0, 0); // R3
    run_case(0, 1, 1, 5, 0, 1, 0, 0); // R8 cached key present
    run_case(0, 0, 0, 0, 0, 1, 0, 0); // R5
    run_case(0, 0, 1, 1, 0, 1, 0, 0); // R6 A
    run_case(0, 0, 1, 1, 2, 1, 0, 0); // R6 priority over small
    run_case(0, 0, 1, 1, 1, 1, 0, 0); // R7 A
    run_case(0, 0, 1, 2, 0, 1, 0, 0); // R6 R
    run_case(0, 0, 1, 2, 1, 1, 1, 0); // R7 R
    run_case(0, 0, 1, 5, 0, 0, 0, 0); // R8 mismatch
    run_case(0, 0, 1, 5, 0, 1, 1, 0); // R10
    run_case(0, 0, 1, 5, 0, 1, 0, 1); // R9 busy commands ignored
    for (int i = 0; i < 60; i++)
      run_case($urandom % 8 == 0, $urandom % 2, $urandom % 4 != 0, int'($urandom % 6) - 1,
               $urandom % 3, $urandom % 2, $urandom % 2, $urandom % 2);
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (100000) @(posedge clk_i);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule